// File: doc/BRIEF.md
# Programmable Transition-Mapped Event Counter

This block counts events on up to three digital input channels according to a table that software loads. Each channel is fed from a selectable external pin through a two-flop synchronizer. The active channels form a small state word. Whenever that word differs from its value one clock earlier, the block looks up the table entry addressed by the pair {previous state, current state}. The entry decides whether the 32-bit count is held, incremented or decremented, or whether the step is illegal.

An entry can also copy the count into an 8-deep capture FIFO, and it can raise a sticky interrupt. Both happen in the same cycle as the count update. Because the table covers every ordered pair of states, it can express a plain gated counter, an up/down counter or a full quadrature decoder. Software reads captured values from the FIFO whenever it likes. A sticky error flag records illegal steps, and a sticky overflow flag records captures that were lost because the FIFO was full.

Top module: `trans_event_counter`

## Requirements
- R1: Each pin passes through two synchronizing flops. A pin change that is set up before rising edge 1 updates `count_o` at rising edge 3, and not before.
- R2: A write with `cfg_sel_i`=0 stores `cfg_data_i[3:0]` into table entry `cfg_addr_i`. The address is {previous state in bits [5:3], current state in bits [2:0]}. Entry bits [1:0] give the action: 00 hold, 01 +1, 10 -1, 11 illegal. Bit 2 requests a capture and bit 3 requests an interrupt. After reset every entry is 0.
- R3: The count is 32 bits wide and wraps modulo 2^32. Decrementing 0 gives 0xFFFFFFFF, and incrementing 0xFFFFFFFF gives 0.
- R4: An illegal step leaves the count unchanged and sets `err_o`. `err_o` stays set until `clr_i[0]` is pulsed.
- R5: A capture pushes the count value from before that step's update into the FIFO, in the same cycle as the update. Values are read out in push order.
- R6: A capture while the FIFO holds 8 values is dropped and sets `ovf_o`, which stays set until `clr_i[1]` is pulsed. A capture is still accepted if a read in the same cycle frees a slot.
- R7: `rd_data_o` shows the oldest value while `rd_valid_o`=1. When the FIFO is empty, `rd_valid_o`=0 and `rd_data_o`=0, and a pulse on `rd_i` has no effect.
- R8: An entry with the interrupt bit set raises `irq_o` when its step occurs. `irq_o` stays set until `clr_i[2]` is pulsed.
- R9: A write with `cfg_sel_i`=1 routes pin number `cfg_data_i` to channel `cfg_addr_i` (0..2). After reset, channel k is fed from pin k. A pin that is not routed to an active channel has no effect.
- R10: A write with `cfg_sel_i`=2 sets the number of active channels to `cfg_data_i` (0 is taken as 1, and values above 3 as 3). Channel k is bit k of the state word. Inactive channels read as 0. After reset, one channel is active.
- R11: Entries whose previous and current states are equal never act, so a state that does not change never alters the count.
- R12: The table can express a gated up counter (two channels, only 10->11 gives +1) and a quadrature decoder (00->01->11->10->00 each +1, the reverse steps each -1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | External asynchronous event pins |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target: 0 table, 1 routing, 2 channel count |
| cfg_addr_i | input | 6 | Table address or channel index |
| cfg_data_i | input | 8 | Configuration write data |
| clr_i | input | 3 | Write-one-to-clear: bit0 error, bit1 overflow, bit2 interrupt |
| count_o | output | 32 | Current count |
| rd_i | input | 1 | FIFO read (pop) strobe |
| rd_data_o | output | 32 | Oldest captured value, 0 when empty |
| rd_valid_o | output | 1 | FIFO holds at least one value |
| err_o | output | 1 | Sticky illegal-step flag |
| ovf_o | output | 1 | Sticky capture-overflow flag |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
A capture push and a software read of the FIFO can land on the same clock edge. The bench first leaves one value in the FIFO. It then raises `rd_i` on exactly the edge where a capturing step updates the count. The scoreboard expects the read to return the older value. A following read must return the newly captured count, and after that the FIFO must be empty. The overflow case is covered too: a ninth capture without any read must be dropped, while the count still advances and `ovf_o` sets.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_INC  = 2'b01,
    ACT_DEC  = 2'b10,
    ACT_BAD  = 2'b11
  } act_e;

  typedef struct packed {
    logic irq;
    logic cap;
    act_e act;
  } entry_t;

  localparam logic [1:0] CFG_TBL   = 2'd0;
  localparam logic [1:0] CFG_ROUTE = 2'd1;
  localparam logic [1:0] CFG_NCH   = 2'd2;
endpackage

// File: rtl/tec_sync.sv
module tec_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tec_decode.sv
module tec_decode
  import tec_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CH   = 3,
  parameter int CFG_DW   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [2*NUM_CH-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0]   cfg_data_i,
  output logic                inc_o,
  output logic                dec_o,
  output logic                bad_o,
  output logic                cap_o,
  output logic                irq_o
);
  localparam int PIN_W = $clog2(NUM_PINS);
  localparam int AW    = 2 * NUM_CH;
  localparam int NENT  = 1 << AW;
  localparam int CW    = $clog2(NUM_CH + 1);

  entry_t             tbl_q [NENT];
  logic [PIN_W-1:0]   route_q [NUM_CH];
  logic [CW-1:0]      nch_q;
  logic [NUM_CH-1:0]  prev_q, cur_st;
  entry_t             ent;
  logic               moved;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NENT; i++) tbl_q[i] <= '0;
    end else if (cfg_we_i && cfg_sel_i == CFG_TBL) begin
      tbl_q[cfg_addr_i] <= entry_t'(cfg_data_i[3:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_CH; k++) route_q[k] <= PIN_W'(k);
      nch_q <= CW'(1);
    end else if (cfg_we_i) begin
      if (cfg_sel_i == CFG_ROUTE && cfg_data_i < CFG_DW'(NUM_PINS)) begin
        for (int k = 0; k < NUM_CH; k++)
          if (cfg_addr_i == AW'(k)) route_q[k] <= cfg_data_i[PIN_W-1:0];
      end
      if (cfg_sel_i == CFG_NCH) begin
        if (cfg_data_i == '0)                     nch_q <= CW'(1);
        else if (cfg_data_i > CFG_DW'(NUM_CH))    nch_q <= CW'(NUM_CH);
        else                                      nch_q <= cfg_data_i[CW-1:0];
      end
    end
  end

  // inactive channels are forced low
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign cur_st[k] = (CW'(k) < nch_q) ? pins_i[route_q[k]] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_st;
  end

  assign moved = (cur_st != prev_q);
  assign ent   = tbl_q[{prev_q, cur_st}];
  assign inc_o = moved && ent.act == ACT_INC;
  assign dec_o = moved && ent.act == ACT_DEC;
  assign bad_o = moved && ent.act == ACT_BAD;
  assign cap_o = moved && ent.cap;
  assign irq_o = moved && ent.irq;
endmodule

// File: rtl/tec_fifo.sv
module tec_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         valid_o,
  output logic         drop_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          empty, full, do_pop, do_push;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LW'(DEPTH));
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign drop_o  = push_i && !do_push;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  assign valid_o = !empty;
  assign dout_o  = empty ? '0 : mem_q[rd_q];
endmodule

// File: rtl/trans_event_counter.sv
module trans_event_counter #(
  parameter int NUM_PINS = 8,
  parameter int NUM_CH   = 3,
  parameter int CFG_DW   = 8,
  parameter int CNT_W    = 32,
  parameter int FIFO_D   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [2*NUM_CH-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0]   cfg_data_i,
  input  logic [2:0]          clr_i,
  output logic [CNT_W-1:0]    count_o,
  input  logic                rd_i,
  output logic [CNT_W-1:0]    rd_data_o,
  output logic                rd_valid_o,
  output logic                err_o,
  output logic                ovf_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pins_s;
  logic inc, dec, bad, cap, irq_ev, drop;
  logic [CNT_W-1:0] cnt_q;
  logic err_q, ovf_q, irq_q;

  tec_sync #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_i), .q_o(pins_s)
  );

  tec_decode #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH), .CFG_DW(CFG_DW)) u_dec (
    .clk_i, .rst_ni, .pins_i(pins_s),
    .cfg_we_i, .cfg_sel_i, .cfg_addr_i, .cfg_data_i,
    .inc_o(inc), .dec_o(dec), .bad_o(bad), .cap_o(cap), .irq_o(irq_ev)
  );

  // capture takes the value before this step's update
  tec_fifo #(.W(CNT_W), .DEPTH(FIFO_D)) u_fifo (
    .clk_i, .rst_ni, .push_i(cap), .din_i(cnt_q), .pop_i(rd_i),
    .dout_o(rd_data_o), .valid_o(rd_valid_o), .drop_o(drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (inc)      cnt_q <= cnt_q + 1'b1;
      else if (dec) cnt_q <= cnt_q - 1'b1;
      // set wins over a same-cycle clear
      err_q <= bad    | (err_q & ~clr_i[0]);
      ovf_q <= drop   | (ovf_q & ~clr_i[1]);
      irq_q <= irq_ev | (irq_q & ~clr_i[2]);
    end
  end

  assign count_o = cnt_q;
  assign err_o   = err_q;
  assign ovf_o   = ovf_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             rd_valid_o,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             err_o,
  input logic             ovf_o,
  input logic             irq_o
);
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1
              || count_o == $past(count_o) - 1'b1));

  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i[0]) |=> err_o);

  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i[1]) |=> ovf_o);

  p_empty_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0));

  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i[2]) |=> irq_o);
endmodule

bind trans_event_counter tec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .count_o(count_o),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
  .err_o(err_o), .ovf_o(ovf_o), .irq_o(irq_o)
);

// File: tb/trans_event_counter_bench.sv
`timescale 1ns/1ps
module trans_event_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [2:0]  clr = '0;
  logic        rd = 1'b0;
  logic [31:0] count, rd_data;
  logic        rd_valid, err, ovf, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_cnt = '0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  trans_event_counter u_trans_event_counter (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .clr_i(clr), .count_o(count), .rd_i(rd), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .err_o(err), .ovf_o(ovf), .irq_o(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, logic [5:0] addr, logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear(logic [2:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = '0;
  endtask

  task automatic step(logic [7:0] v);
    @(negedge clk); pins = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fifo_read();
    @(negedge clk); rd = 1'b1;
    @(posedge clk);
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [3:0] quad_ent(int a);
    logic [2:0] p, c;
    int pp, pc, d;
    p = 3'(a >> 3); c = 3'(a);
    if (p[2] || c[2]) return 4'h0;
    pp = (p[1:0] == 2'b00) ? 0 : (p[1:0] == 2'b01) ? 1 : (p[1:0] == 2'b11) ? 2 : 3;
    pc = (c[1:0] == 2'b00) ? 0 : (c[1:0] == 2'b01) ? 1 : (c[1:0] == 2'b11) ? 2 : 3;
    d = (pc - pp + 4) % 4;
    return (d == 1) ? 4'h1 : (d == 3) ? 4'h2 : (d == 2) ? 4'h3 : 4'h0;
  endfunction

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rd) begin
      if (exp_q.size() == 0) chk("R7 empty read", {31'b0, rd_valid, rd_data}, 64'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R5 fifo data", {31'b0, rd_valid, rd_data}, {31'b0, 1'b1, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset count", count, 0);
    chk("R4 reset err", err, 0);
    chk("R6 reset ovf", ovf, 0);
    chk("R8 reset irq", irq, 0);
    chk("R7 reset empty", {rd_valid, rd_data}, 0);

    // gated up counter, two channels
    cfg(2'd2, 6'd0, 8'd2);
    cfg(2'd0, 6'h13, 8'h1);
    step(8'h02); chk("R12 gated 00->10", count, 0);
    @(negedge clk); pins = 8'h03;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R1 not before edge 3", count, 0);
    @(posedge clk); @(negedge clk);
    chk("R1 update at edge 3", count, 1);
    step(8'h02); step(8'h00); step(8'h01); step(8'h03);
    chk("R12 gated other steps", count, 1);
    step(8'h02); step(8'h03);
    chk("R2 gated 10->11", count, 2);
    exp_cnt = 2;

    // quadrature
    for (int a = 0; a < 64; a++) cfg(2'd0, 6'(a), {4'h0, quad_ent(a)});
    step(8'h02); step(8'h00); step(8'h01); step(8'h03);
    chk("R12 quad forward", count, 6);
    step(8'h01); step(8'h00); step(8'h02); step(8'h03);
    step(8'h01); step(8'h00);
    chk("R12 quad reverse", count, 0);
    step(8'h02);
    chk("R3 wrap down", count, 32'hFFFF_FFFF);
    step(8'h00);
    chk("R3 wrap up", count, 0);

    // illegal step
    step(8'h03);
    chk("R4 illegal holds count", count, 0);
    chk("R4 err set", err, 1);
    step(8'h02);
    chk("R4 count after", count, 1);
    chk("R4 err sticky", err, 1);
    clear(3'b001);
    chk("R4 err cleared", err, 0);

    // equal-state entry never acts
    cfg(2'd0, 6'h12, 8'h1);
    repeat (6) @(negedge clk);
    chk("R11 no change on steady state", count, 1);
    step(8'h00);
    chk("R11 quad step", count, 2);

    // one channel
    cfg(2'd2, 6'd0, 8'd0);
    step(8'h02);
    chk("R10 inactive channel ignored", count, 2);
    step(8'h00); step(8'h01);
    chk("R10 ch0 rise", count, 3);
    step(8'h00);
    chk("R10 ch0 fall", count, 2);

    // routing
    cfg(2'd1, 6'd0, 8'd5);
    step(8'h01);
    chk("R9 unrouted pin ignored", count, 2);
    step(8'h00); step(8'h20);
    chk("R9 routed pin counts", count, 3);
    step(8'h00);
    chk("R9 routed fall", count, 2);
    exp_cnt = 2;

    // capture + interrupt on rise, hold on fall
    cfg(2'd0, 6'h01, 8'hD);
    cfg(2'd0, 6'h08, 8'h0);
    for (int i = 0; i < 9; i++) begin
      if (i < 8) exp_q.push_back(exp_cnt);
      exp_cnt++;
      step(8'h20);
      if (i == 0) chk("R8 irq raised", irq, 1);
      step(8'h00);
    end
    chk("R6 count advances on dropped capture", count, exp_cnt);
    chk("R6 ovf set", ovf, 1);
    clear(3'b100);
    chk("R8 irq cleared", irq, 0);
    chk("R6 ovf sticky", ovf, 1);
    clear(3'b010);
    chk("R6 ovf cleared", ovf, 0);
    for (int i = 0; i < 8; i++) fifo_read();
    chk("R7 empty after drain", {rd_valid, rd_data}, 0);
    fifo_read();
    chk("R7 read on empty no effect", {rd_valid, rd_data}, 0);

    // capture coinciding with a read
    exp_q.push_back(exp_cnt); exp_cnt++;
    step(8'h20); step(8'h00);
    exp_q.push_back(exp_cnt); exp_cnt++;
    @(negedge clk); pins = 8'h20;
    repeat (2) @(posedge clk);
    @(negedge clk); rd = 1'b1;
    @(posedge clk);
    @(negedge clk); rd = 1'b0;
    chk("R5 count with concurrent read", count, exp_cnt);
    chk("R6 push accepted with pop", ovf, 0);
    fifo_read();
    chk("R5 fifo empty after both", {rd_valid, rd_data}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule